// File: doc/BRIEF.md
# Processor Run-State Controller

This block keeps the top-level run state of a microcoded processor core. It decides whether the core is executing instructions, handling a group 0/1 exception, holding peripherals in reset after a reset instruction, or locked up after a double fault. It also keeps the supervisor bit and the interrupt mask. Instruction decode, the datapath and exception stack frames are handled elsewhere and talk to this block through single-cycle strobes.

After reset is released, the block reads the initial supervisor stack pointer and then the initial program counter through a simple request/acknowledge read port. It then hands control to instruction processing. The interrupt priority input is evaluated only on the strobe that marks the end of an instruction. A reset instruction drives the peripheral reset output for a fixed count of bus-cycle ticks. While that count runs, instruction fetch is held off.

Top module: `run_state_ctrl`

## Requirements
- R1: `rst_n` is asynchronous and active low. While it is low, and right after release, `state_o` is 1 (exception processing), `super_o`=1, `mask_o`=7, `fetch_en`=0, `reset_out`=0, `blocked`=0, and `bus_req`=1 with `bus_addr`=0. The `state_o` encoding is 0 run, 1 exception, 2 peripheral reset, 3 blocked.
- R2: A `bus_ack` while `bus_addr`=0 loads `bus_rdata` into `init_ssp` and moves `bus_addr` to 1. A `bus_ack` at address 1 loads `init_pc`, drops `bus_req` and sets `state_o` to 0, all on the same edge.
- R3: While `bus_req` is high, `bus_fc` is 6 (supervisor program space).
- R4: In run state with `super_o`=1, `ins_start` with `ins_reset` sets `reset_out`=1 and `state_o`=2 on the next edge. `reset_out` stays high for exactly `RST_TICKS` (default 124) cycles in which `tick` is high. It falls on the edge of the last such tick, and `state_o` returns to 0 on that same edge.
- R5: `fetch_en` is 1 only when `state_o` is 0, so it is 0 whenever `reset_out` is 1.
- R6: `bus_fault` in run state moves the block to state 1. A second `bus_fault` in state 1, or `bus_err` during the vector reads, moves it to state 3 with `blocked`=1.
- R7: State 3 is left only through `rst_n`. Every other input leaves `state_o`, `blocked` and `fetch_en` unchanged there.
- R8: `ins_start` with `ins_priv` or `ins_reset` while `super_o`=0 gives a one-cycle `priv_exc` pulse. It also sets `state_o`=1 and `super_o`=1 and leaves `reset_out` low.
- R9: `ipl` is evaluated only on a run-state cycle with `ins_end`=1. Changes of `ipl` at any other time have no effect.
- R10: An interrupt is accepted when `ipl` > `mask_o` or `ipl`=7. On acceptance, `irq_take` pulses for one cycle, `irq_lvl`=`ipl`, `mask_o` takes the level, `super_o`=1 and `state_o`=1.
- R11: `exc_done` in state 1 returns the block to state 0 once the vector reads have finished. During the vector reads it is ignored.
- R12: `sr_wr` in run state, with no higher-priority event, loads `sr_super` into `super_o` and `sr_mask` into `mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Vector read request |
| bus_addr | output | ADDR_W | Longword address of the vector read |
| bus_fc | output | 3 | Function code of the vector read |
| bus_ack | input | 1 | Vector read completed, data valid |
| bus_err | input | 1 | Vector read failed |
| bus_rdata | input | DATA_W | Vector read data |
| init_ssp | output | DATA_W | Captured initial stack pointer |
| init_pc | output | DATA_W | Captured initial program counter |
| ins_start | input | 1 | First cycle of an instruction |
| ins_priv | input | 1 | Instruction is privileged |
| ins_reset | input | 1 | Instruction is the peripheral reset instruction |
| ins_end | input | 1 | Instruction boundary |
| exc_done | input | 1 | Exception sequence finished |
| bus_fault | input | 1 | Bus error reported by an execution bus cycle |
| tick | input | 1 | One bus-cycle-equivalent elapsed |
| ipl | input | 3 | Interrupt priority level |
| sr_wr | input | 1 | Status write strobe |
| sr_super | input | 1 | Supervisor bit to write |
| sr_mask | input | 3 | Mask to write |
| state_o | output | 2 | Run state |
| fetch_en | output | 1 | Instruction fetch permitted |
| super_o | output | 1 | Supervisor mode |
| mask_o | output | 3 | Interrupt mask |
| irq_take | output | 1 | Interrupt accepted pulse |
| irq_lvl | output | 3 | Level of the accepted interrupt |
| priv_exc | output | 1 | Privilege violation pulse |
| reset_out | output | 1 | Peripheral reset |
| blocked | output | 1 | Locked after double fault |

## Verification
Several properties are checked by assertions on every cycle:
- the blocked state never exits;
- fetch stays off while the peripheral reset is high;
- the vector reads use function code 6;
- an interrupt is only taken on the cycle after an instruction boundary;
- a privilege pulse always coincides with exception state;
- the tick counter stays inside its window.

Other behaviours only the bench scenarios can show:
- the exact 124-tick length of the reset pulse, with gaps between ticks;
- the data captured by the two vector reads;
- the mask comparison over a table of level/mask pairs;
- the fact that `ipl` is ignored between boundaries.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    RS_RUN   = 2'd0,
    RS_EXC   = 2'd1,
    RS_XRST  = 2'd2,
    RS_BLOCK = 2'd3
  } run_state_t;

  localparam logic [2:0] FC_SUP_PROG = 3'd6;
  localparam logic [2:0] MASK_ALL    = 3'd7;
endpackage

// File: rtl/rsc_vec_fetch.sv
module rsc_vec_fetch #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_fc,
  output logic [DATA_W-1:0] ssp_q,
  output logic [DATA_W-1:0] pc_q,
  output logic              fetch_last,
  output logic              fetch_err
);
  import rsc_pkg::*;

  logic second;

  assign bus_fc     = FC_SUP_PROG;
  assign fetch_last = bus_req & bus_ack & second;
  assign fetch_err  = bus_req & bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req  <= 1'b1;
      bus_addr <= '0;
      second   <= 1'b0;
      ssp_q    <= '0;
      pc_q     <= '0;
    end else if (bus_req && !bus_err && bus_ack) begin
      if (!second) begin
        ssp_q    <= bus_rdata;
        second   <= 1'b1;
        bus_addr <= ADDR_W'(1);
      end else begin
        pc_q    <= bus_rdata;
        bus_req <= 1'b0;
      end
    end else if (bus_req && bus_err) begin
      bus_req <= 1'b0;
    end
  end

  // R3
  vec_fc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_fc == 3'd6));
endmodule

// File: rtl/rsc_reset_timer.sv
module rsc_reset_timer #(
  parameter int RST_TICKS = 124
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active,
  output logic last
);
  localparam int CW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt;

  assign last = active & tick & (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST_CNT) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= LAST_CNT));
endmodule

// File: rtl/rsc_irq_gate.sv
module rsc_irq_gate #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mask,
  output logic             accept
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;
  assign accept = (level == TOP_LVL) || (level > mask);
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl #(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int RST_TICKS = 124
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_fc,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] init_ssp,
  output logic [DATA_W-1:0] init_pc,
  input  logic              ins_start,
  input  logic              ins_priv,
  input  logic              ins_reset,
  input  logic              ins_end,
  input  logic              exc_done,
  input  logic              bus_fault,
  input  logic              tick,
  input  logic [2:0]        ipl,
  input  logic              sr_wr,
  input  logic              sr_super,
  input  logic [2:0]        sr_mask,
  output logic [1:0]        state_o,
  output logic              fetch_en,
  output logic              super_o,
  output logic [2:0]        mask_o,
  output logic              irq_take,
  output logic [2:0]        irq_lvl,
  output logic              priv_exc,
  output logic              reset_out,
  output logic              blocked
);
  import rsc_pkg::*;

  run_state_t st;
  logic fetch_last, fetch_err, irq_ok, xr_last;
  logic in_run, priv_hit, xr_go;

  rsc_vec_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .ssp_q(init_ssp), .pc_q(init_pc),
    .fetch_last(fetch_last), .fetch_err(fetch_err)
  );

  rsc_reset_timer #(.RST_TICKS(RST_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(xr_go), .tick(tick),
    .active(reset_out), .last(xr_last)
  );

  rsc_irq_gate #(.LVL_W(3)) u_gate (
    .level(ipl), .mask(mask_o), .accept(irq_ok)
  );

  assign in_run   = (st == RS_RUN);
  assign priv_hit = in_run & !bus_fault & ins_start & (ins_priv | ins_reset) & !super_o;
  assign xr_go    = in_run & !bus_fault & ins_start & ins_reset & super_o;

  assign state_o  = st;
  assign fetch_en = in_run;
  assign blocked  = (st == RS_BLOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RS_EXC;
      super_o  <= 1'b1;
      mask_o   <= MASK_ALL;
      irq_take <= 1'b0;
      irq_lvl  <= '0;
      priv_exc <= 1'b0;
    end else begin
      irq_take <= 1'b0;
      priv_exc <= 1'b0;
      unique case (st)
        RS_RUN: begin
          if (bus_fault) begin
            st      <= RS_EXC;
            super_o <= 1'b1;
          end else if (priv_hit) begin
            st       <= RS_EXC;
            super_o  <= 1'b1;
            priv_exc <= 1'b1;
          end else if (xr_go) begin
            st <= RS_XRST;
          end else if (ins_end && irq_ok) begin
            st       <= RS_EXC;
            super_o  <= 1'b1;
            mask_o   <= ipl;
            irq_lvl  <= ipl;
            irq_take <= 1'b1;
          end else if (sr_wr) begin
            super_o <= sr_super;
            mask_o  <= sr_mask;
          end
        end
        RS_EXC: begin
          if (bus_req) begin
            if (fetch_err)       st <= RS_BLOCK;
            else if (fetch_last) st <= RS_RUN;
          end else if (bus_fault) begin
            st <= RS_BLOCK;
          end else if (exc_done) begin
            st <= RS_RUN;
          end
        end
        RS_XRST: begin
          if (xr_last) st <= RS_RUN;
        end
        default: st <= RS_BLOCK;
      endcase
    end
  end

  // R7
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> blocked);
  // R5
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_out |-> !fetch_en);
  // R9
  irq_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(ins_end));
  // R8
  priv_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_exc |-> (state_o == 2'd1 && !reset_out));
endmodule

// File: tb/run_state_ctrl_tb.sv
module run_state_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req, bus_ack = 0, bus_err = 0;
  logic [29:0] bus_addr;
  logic [2:0] bus_fc;
  logic [31:0] bus_rdata = '0, init_ssp, init_pc;
  logic ins_start = 0, ins_priv = 0, ins_reset = 0, ins_end = 0;
  logic exc_done = 0, bus_fault = 0, tick = 0, sr_wr = 0, sr_super = 0;
  logic [2:0] ipl = '0, sr_mask = '0, mask_o, irq_lvl;
  logic [1:0] state_o;
  logic fetch_en, super_o, irq_take, priv_exc, reset_out, blocked;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  run_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .init_ssp(init_ssp), .init_pc(init_pc),
    .ins_start(ins_start), .ins_priv(ins_priv), .ins_reset(ins_reset),
    .ins_end(ins_end), .exc_done(exc_done), .bus_fault(bus_fault),
    .tick(tick), .ipl(ipl), .sr_wr(sr_wr), .sr_super(sr_super),
    .sr_mask(sr_mask), .state_o(state_o), .fetch_en(fetch_en),
    .super_o(super_o), .mask_o(mask_o), .irq_take(irq_take),
    .irq_lvl(irq_lvl), .priv_exc(priv_exc), .reset_out(reset_out),
    .blocked(blocked)
  );

  // {mask, ipl, accept}
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 3'd0, 1'b0}, {3'd0, 3'd1, 1'b1}, {3'd3, 3'd3, 1'b0},
    {3'd3, 3'd4, 1'b1}, {3'd6, 3'd5, 1'b0}, {3'd6, 3'd7, 1'b1},
    {3'd7, 3'd7, 1'b1}, {3'd7, 3'd6, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic boot(input logic [31:0] s, input logic [31:0] p);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    bus_ack = 1; bus_rdata = s; step();
    bus_ack = 1; bus_rdata = p; step();
    bus_ack = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 1); chk("R1 super", super_o, 1);
    chk("R1 mask", mask_o, 7); chk("R1 fetch", fetch_en, 0);
    chk("R1 rstout", reset_out, 0); chk("R1 blocked", blocked, 0);
    chk("R1 req", bus_req, 1); chk("R1 addr", bus_addr, 0);
    chk("R3 fc", bus_fc, 6);
    rst_n = 1'b1;
    step();
    chk("R1 req after release", bus_req, 1);
    // R11 exc_done ignored during vector reads
    exc_done = 1; step(); exc_done = 0;
    chk("R11 ignored in boot", state_o, 1);
    // R2 vector reads
    bus_ack = 1; bus_rdata = 32'h0000_1F00; step(); bus_ack = 0;
    chk("R2 ssp", init_ssp, 32'h0000_1F00); chk("R2 addr1", bus_addr, 1);
    chk("R3 fc second", bus_fc, 6); chk("R2 still exc", state_o, 1);
    step();
    bus_ack = 1; bus_rdata = 32'h0000_0400; step(); bus_ack = 0;
    chk("R2 pc", init_pc, 32'h0000_0400); chk("R2 req drop", bus_req, 0);
    chk("R2 run", state_o, 0); chk("R5 fetch on", fetch_en, 1);

    // R10 vector table walk
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m, l;
      logic e;
      {m, l, e} = VEC[i];
      sr_wr = 1; sr_super = 1; sr_mask = m; step(); sr_wr = 0;
      chk("R12 mask load", mask_o, m);
      ipl = l; ins_end = 1; step(); ins_end = 0; ipl = 0;
      chk("R10 take", irq_take, e);
      chk("R10 state", state_o, e ? 1 : 0);
      chk("R10 mask", mask_o, e ? l : m);
      if (e) begin
        chk("R10 lvl", irq_lvl, l);
        step(); chk("R10 pulse one cycle", irq_take, 0);
        exc_done = 1; step(); exc_done = 0;
        chk("R11 back to run", state_o, 0);
      end
    end

    // R9 ipl ignored off boundary
    sr_wr = 1; sr_super = 0; sr_mask = 0; step(); sr_wr = 0;
    chk("R12 user", super_o, 0);
    ipl = 3'd5;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 no take", irq_take, 0);
    end
    chk("R9 still run", state_o, 0);
    ipl = 0; ins_end = 1; step(); ins_end = 0;
    chk("R9 level gone", irq_take, 0);

    // R8 privilege violation incl reset instruction in user mode
    ins_start = 1; ins_reset = 1; step(); ins_start = 0; ins_reset = 0;
    chk("R8 pulse", priv_exc, 1); chk("R8 state", state_o, 1);
    chk("R8 super", super_o, 1); chk("R8 no rstout", reset_out, 0);
    step(); chk("R8 one cycle", priv_exc, 0);
    exc_done = 1; step(); exc_done = 0;
    sr_wr = 1; sr_super = 0; sr_mask = 0; step(); sr_wr = 0;
    ins_start = 1; ins_priv = 1; step(); ins_start = 0; ins_priv = 0;
    chk("R8 priv pulse", priv_exc, 1);
    exc_done = 1; step(); exc_done = 0;

    // R4 reset instruction in supervisor mode, ticks with gaps
    ins_start = 1; ins_reset = 1; step(); ins_start = 0; ins_reset = 0;
    chk("R4 rstout", reset_out, 1); chk("R4 state", state_o, 2);
    chk("R5 fetch off", fetch_en, 0);
    for (int t = 0; t < 123; t++) begin
      tick = 1; step(); tick = 0;
      if (t % 3 == 0) step();
    end
    chk("R4 held at 123", reset_out, 1); chk("R4 state at 123", state_o, 2);
    chk("R5 fetch off at 123", fetch_en, 0);
    tick = 1; step(); tick = 0;
    chk("R4 fall at 124", reset_out, 0); chk("R4 run", state_o, 0);

    // R6 double fault, R7 lock
    bus_fault = 1; step(); bus_fault = 0;
    chk("R6 first fault", state_o, 1); chk("R6 not blocked", blocked, 0);
    bus_fault = 1; step(); bus_fault = 0;
    chk("R6 blocked", blocked, 1); chk("R6 state", state_o, 3);
    exc_done = 1; ins_end = 1; ipl = 7; ins_start = 1; sr_wr = 1; tick = 1;
    step(); step();
    exc_done = 0; ins_end = 0; ipl = 0; ins_start = 0; sr_wr = 0; tick = 0;
    chk("R7 stays", state_o, 3); chk("R7 blocked", blocked, 1);
    chk("R7 no fetch", fetch_en, 0); chk("R7 no irq", irq_take, 0);

    // R6 error during vector read
    rst_n = 0; step(); rst_n = 1;
    chk("R7 reset clears", blocked, 0);
    bus_err = 1; step(); bus_err = 0;
    chk("R6 boot err", state_o, 3);

    boot(32'hAA, 32'hBB);
    chk("R2 reboot pc", init_pc, 32'hBB); chk("R2 reboot run", state_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule